// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame is kept or thrown away. The receive path presents the frame's 48-bit destination address with a strobe. One clock later the filter reports an address verdict: accept or drop, with a reason code. When the frame ends, the receive path presents the total length, counting the 4-byte CRC, and a CRC-good flag. One clock later the filter reports the final frame verdict, which combines the address decision with the length limit and the CRC status.

Matching runs against a small table of exact addresses. Each entry has its own enable bit. Slot 0 is intended for the station's own unicast address and the remaining slots for multicast groups. Three bypass modes sit next to the table: pass broadcast, pass every group address, and pass every individual address. Setting both group and individual passing gives promiscuous operation. Configuration goes through a simple write port. Reset disables everything, so every frame is dropped until software sets the block up.

Top module: `eth_da_filter`

## Requirements
- R1: After reset the entry enables and all mode bits are zero and the length limit is 1518. Both verdict strobes are low. Every address is then dropped with reason 0 (no match).
- R2: `addr_vld_o` is high exactly in the cycle after a cycle with `da_valid_i` high. `addr_acc_o` and `addr_rsn_o` are updated only at that time and hold their values otherwise.
- R3: Table entry i (i from 0 to 14) is written as two words. The high word goes to config address 2i and carries address bytes 0 to 3, with byte 0 in bits 31:24. The low word goes to address 2i+1 and carries bytes 4 and 5 in bits 31:16. Byte 0 is the first byte on the wire and maps to `da_i[47:40]`. An entry matches only when all 48 bits are equal.
- R4: Config address 30 holds the entry enable mask, with bit i enabling entry i. A disabled entry never matches. Writing the value 1 leaves only entry 0 active.
- R5: Config address 31 holds the mode bits. Bit 0 is the table compare enable. While it is 0, no entry matches.
- R6: Mode bit 1 accepts the all-ones address with reason 1, whether or not the table matches.
- R7: Mode bit 2 accepts every address whose group bit (`da_i[40]`, bit 0 of byte 0) is set, with reason 3.
- R8: Mode bit 3 accepts every address whose group bit is clear, with reason 4. Setting bits 2 and 3 together accepts every address.
- R9: The address reason follows a fixed priority: broadcast (1), then table hit (2), then all-group (3), then all-individual (4). Otherwise the address is dropped with reason 0.
- R10: Config address 32 holds the maximum frame length. `frm_vld_o` is high exactly in the cycle after `eof_valid_i`. For an accepted address, a length (CRC included) greater than the limit drops the frame with reason 5. A length equal to the limit is accepted.
- R11: For an accepted address within the length limit, a low `eof_crc_ok_i` drops the frame with reason 6. If the address was dropped, the frame is dropped with reason 0 regardless of its length and CRC. A too-long frame reports reason 5 even when its CRC is also bad. An accepted frame carries the reason of its address verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW (6) | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| da_valid_i | input | 1 | Destination address strobe |
| da_i | input | 48 | Destination address, byte 0 in bits 47:40 |
| eof_valid_i | input | 1 | End-of-frame strobe |
| eof_len_i | input | LEN_W (16) | Frame length in bytes, CRC included |
| eof_crc_ok_i | input | 1 | CRC of the frame was good |
| addr_vld_o | output | 1 | Address verdict strobe |
| addr_acc_o | output | 1 | Address accepted |
| addr_rsn_o | output | 3 | Address reason code |
| frm_vld_o | output | 1 | Frame verdict strobe |
| frm_acc_o | output | 1 | Frame accepted |
| frm_rsn_o | output | 3 | Frame reason code |

## Verification
The hardest case to reach is one where several acceptance paths claim the same address at once. Examples are the all-ones address with broadcast, group passing and a table entry all active, or an own-address hit while individual passing is on. Here only the priority order decides the reason code. The stimulus loads a broadcast entry and a group entry into the table and turns on all four mode bits. It then walks addresses of each class through the filter. After that, a long stretch of random mode and mask rewrites is mixed with frames drawn from a pool that straddles every class and the length boundary, and the behavioural reference model is compared on every clock.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;

  localparam int DA_W     = 48;
  localparam int CFG_DW   = 32;
  localparam int RSN_W    = 3;
  localparam int GROUP_BIT = 40;

  typedef enum logic [RSN_W-1:0] {
    RSN_NOMATCH = 3'd0,
    RSN_BCAST   = 3'd1,
    RSN_TABLE   = 3'd2,
    RSN_ALLGRP  = 3'd3,
    RSN_ALLIND  = 3'd4,
    RSN_TOOLONG = 3'd5,
    RSN_BADCRC  = 3'd6
  } reason_e;

  typedef struct packed {
    logic all_ind;
    logic all_grp;
    logic bcast;
    logic cmp_en;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/da_filter_cfg.sv
module da_filter_cfg
  import da_filter_pkg::*;
#(
  parameter int NUM_ENT     = 15,
  parameter int LEN_W       = 16,
  parameter int MAX_LEN_RST = 1518,
  parameter int CFG_AW      = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [CFG_AW-1:0]            waddr_i,
  input  logic [CFG_DW-1:0]            wdata_i,
  output logic [NUM_ENT-1:0][DA_W-1:0] entry_o,
  output logic [NUM_ENT-1:0]           ena_o,
  output mode_t                        mode_o,
  output logic [LEN_W-1:0]             max_len_o
);

  localparam int SEL_MASK = 2 * NUM_ENT;
  localparam int SEL_MODE = 2 * NUM_ENT + 1;
  localparam int SEL_MAXL = 2 * NUM_ENT + 2;
  localparam int LO_W     = DA_W - CFG_DW;

  // per-entry storage: two words per slot
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [CFG_DW-1:0] hi_q, hi_d;
    logic [LO_W-1:0]   lo_q, lo_d;
    logic              hi_en, lo_en;

    assign hi_en = we_i && (waddr_i == CFG_AW'(2 * i));
    assign lo_en = we_i && (waddr_i == CFG_AW'(2 * i + 1));

    always_comb begin
      hi_d = hi_q;
      lo_d = lo_q;
      if (hi_en) hi_d = wdata_i;
      if (lo_en) lo_d = wdata_i[CFG_DW-1 -: LO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end

    assign entry_o[i] = {hi_q, lo_q};
  end

  logic [NUM_ENT-1:0] ena_q, ena_d;
  mode_t              mode_q, mode_d;
  logic [LEN_W-1:0]   maxl_q, maxl_d;
  logic               ena_we, mode_we, maxl_we;

  assign ena_we  = we_i && (waddr_i == CFG_AW'(SEL_MASK));
  assign mode_we = we_i && (waddr_i == CFG_AW'(SEL_MODE));
  assign maxl_we = we_i && (waddr_i == CFG_AW'(SEL_MAXL));

  always_comb begin
    ena_d  = ena_q;
    mode_d = mode_q;
    maxl_d = maxl_q;
    if (ena_we)  ena_d  = wdata_i[NUM_ENT-1:0];
    if (mode_we) mode_d = mode_t'(wdata_i[MODE_W-1:0]);
    if (maxl_we) maxl_d = wdata_i[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      mode_q <= '0;
      maxl_q <= LEN_W'(MAX_LEN_RST);
    end else begin
      ena_q  <= ena_d;
      mode_q <= mode_d;
      maxl_q <= maxl_d;
    end
  end

  assign ena_o     = ena_q;
  assign mode_o    = mode_q;
  assign max_len_o = maxl_q;

endmodule

// File: rtl/da_filter_cam.sv
module da_filter_cam
  import da_filter_pkg::*;
#(
  parameter int NUM_ENT = 15
) (
  input  logic [DA_W-1:0]              da_i,
  input  logic [NUM_ENT-1:0][DA_W-1:0] entry_i,
  input  logic [NUM_ENT-1:0]           ena_i,
  input  logic                         cmp_en_i,
  output logic                         hit_o
);

  logic [NUM_ENT-1:0] hit_vec;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign hit_vec[i] = ena_i[i] && (entry_i[i] == da_i);
  end

  assign hit_o = cmp_en_i && (|hit_vec);

endmodule

// File: rtl/da_filter_decide.sv
module da_filter_decide
  import da_filter_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             da_valid_i,
  input  logic [DA_W-1:0]  da_i,
  input  logic             tbl_hit_i,
  input  mode_t            mode_i,
  input  logic             eof_valid_i,
  input  logic [LEN_W-1:0] eof_len_i,
  input  logic             eof_crc_ok_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             addr_vld_o,
  output logic             addr_acc_o,
  output reason_e          addr_rsn_o,
  output logic             frm_vld_o,
  output logic             frm_acc_o,
  output reason_e          frm_rsn_o
);

  logic    is_bcast, is_group;
  reason_e a_rsn_c;
  reason_e f_rsn_c;

  assign is_bcast = &da_i;
  assign is_group = da_i[GROUP_BIT];

  // address classification, fixed priority
  always_comb begin
    if (mode_i.bcast && is_bcast)          a_rsn_c = RSN_BCAST;
    else if (tbl_hit_i)                    a_rsn_c = RSN_TABLE;
    else if (mode_i.all_grp && is_group)   a_rsn_c = RSN_ALLGRP;
    else if (mode_i.all_ind && !is_group)  a_rsn_c = RSN_ALLIND;
    else                                   a_rsn_c = RSN_NOMATCH;
  end

  logic    a_vld_q, a_vld_d;
  logic    a_acc_q, a_acc_d;
  reason_e a_rsn_q, a_rsn_d;

  always_comb begin
    a_vld_d = da_valid_i;
    a_acc_d = a_acc_q;
    a_rsn_d = a_rsn_q;
    if (da_valid_i) begin
      a_acc_d = (a_rsn_c != RSN_NOMATCH);
      a_rsn_d = a_rsn_c;
    end
  end

  // frame verdict from held address result, length and CRC
  always_comb begin
    if (!a_acc_q)                    f_rsn_c = RSN_NOMATCH;
    else if (eof_len_i > max_len_i)  f_rsn_c = RSN_TOOLONG;
    else if (!eof_crc_ok_i)          f_rsn_c = RSN_BADCRC;
    else                             f_rsn_c = a_rsn_q;
  end

  logic    f_vld_q, f_vld_d;
  logic    f_acc_q, f_acc_d;
  reason_e f_rsn_q, f_rsn_d;

  always_comb begin
    f_vld_d = eof_valid_i;
    f_acc_d = f_acc_q;
    f_rsn_d = f_rsn_q;
    if (eof_valid_i) begin
      f_acc_d = a_acc_q && (eof_len_i <= max_len_i) && eof_crc_ok_i;
      f_rsn_d = f_rsn_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q <= 1'b0;
      a_acc_q <= 1'b0;
      a_rsn_q <= RSN_NOMATCH;
      f_vld_q <= 1'b0;
      f_acc_q <= 1'b0;
      f_rsn_q <= RSN_NOMATCH;
    end else begin
      a_vld_q <= a_vld_d;
      a_acc_q <= a_acc_d;
      a_rsn_q <= a_rsn_d;
      f_vld_q <= f_vld_d;
      f_acc_q <= f_acc_d;
      f_rsn_q <= f_rsn_d;
    end
  end

  assign addr_vld_o = a_vld_q;
  assign addr_acc_o = a_acc_q;
  assign addr_rsn_o = a_rsn_q;
  assign frm_vld_o  = f_vld_q;
  assign frm_acc_o  = f_acc_q;
  assign frm_rsn_o  = f_rsn_q;

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
  import da_filter_pkg::*;
#(
  parameter int NUM_ENT     = 15,
  parameter int LEN_W       = 16,
  parameter int MAX_LEN_RST = 1518,
  localparam int CFG_AW     = $clog2(2 * NUM_ENT + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              da_valid_i,
  input  logic [47:0]       da_i,
  input  logic              eof_valid_i,
  input  logic [LEN_W-1:0]  eof_len_i,
  input  logic              eof_crc_ok_i,
  output logic              addr_vld_o,
  output logic              addr_acc_o,
  output logic [2:0]        addr_rsn_o,
  output logic              frm_vld_o,
  output logic              frm_acc_o,
  output logic [2:0]        frm_rsn_o
);

  logic [NUM_ENT-1:0][DA_W-1:0] entry_w;
  logic [NUM_ENT-1:0]           ena_q;
  mode_t                        mode_q;
  logic [LEN_W-1:0]             max_len_q;
  logic                         tbl_hit;
  reason_e                      a_rsn, f_rsn;

  da_filter_cfg #(
    .NUM_ENT     (NUM_ENT),
    .LEN_W       (LEN_W),
    .MAX_LEN_RST (MAX_LEN_RST),
    .CFG_AW      (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we_i),
    .waddr_i   (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .entry_o   (entry_w),
    .ena_o     (ena_q),
    .mode_o    (mode_q),
    .max_len_o (max_len_q)
  );

  da_filter_cam #(
    .NUM_ENT (NUM_ENT)
  ) u_cam (
    .da_i     (da_i),
    .entry_i  (entry_w),
    .ena_i    (ena_q),
    .cmp_en_i (mode_q.cmp_en),
    .hit_o    (tbl_hit)
  );

  da_filter_decide #(
    .LEN_W (LEN_W)
  ) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .da_valid_i   (da_valid_i),
    .da_i         (da_i),
    .tbl_hit_i    (tbl_hit),
    .mode_i       (mode_q),
    .eof_valid_i  (eof_valid_i),
    .eof_len_i    (eof_len_i),
    .eof_crc_ok_i (eof_crc_ok_i),
    .max_len_i    (max_len_q),
    .addr_vld_o   (addr_vld_o),
    .addr_acc_o   (addr_acc_o),
    .addr_rsn_o   (a_rsn),
    .frm_vld_o    (frm_vld_o),
    .frm_acc_o    (frm_acc_o),
    .frm_rsn_o    (f_rsn)
  );

  assign addr_rsn_o = a_rsn;
  assign frm_rsn_o  = f_rsn;

endmodule

// File: rtl/da_filter_chk.sv
module da_filter_chk
  import da_filter_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             da_valid_i,
  input logic [47:0]      da_i,
  input logic             eof_valid_i,
  input logic [LEN_W-1:0] eof_len_i,
  input mode_t            mode_q,
  input logic [LEN_W-1:0] max_len_q,
  input logic             addr_vld_o,
  input logic             addr_acc_o,
  input logic [2:0]       addr_rsn_o,
  input logic             frm_vld_o,
  input logic             frm_acc_o,
  input logic [2:0]       frm_rsn_o
);

  assert_addr_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid_i |=> addr_vld_o);

  assert_addr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid_i |=> (!addr_vld_o && $stable(addr_acc_o) && $stable(addr_rsn_o)));

  assert_unconfigured_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && mode_q == '0) |=> (!addr_acc_o && addr_rsn_o == 3'd0));

  assert_bcast_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && (&da_i) && mode_q.bcast) |=> (addr_acc_o && addr_rsn_o == 3'd1));

  assert_group_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && da_i[40] && mode_q.all_grp) |=> addr_acc_o);

  assert_indiv_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid_i && !da_i[40] && mode_q.all_ind) |=> addr_acc_o);

  assert_frame_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eof_valid_i |=> frm_vld_o);

  assert_too_long_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_valid_i && eof_len_i > max_len_q) |=> !frm_acc_o);

  assert_accept_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld_o && frm_acc_o) |-> (frm_rsn_o >= 3'd1 && frm_rsn_o <= 3'd4));

endmodule

bind eth_da_filter da_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .da_valid_i  (da_valid_i),
  .da_i        (da_i),
  .eof_valid_i (eof_valid_i),
  .eof_len_i   (eof_len_i),
  .mode_q      (mode_q),
  .max_len_q   (max_len_q),
  .addr_vld_o  (addr_vld_o),
  .addr_acc_o  (addr_acc_o),
  .addr_rsn_o  (addr_rsn_o),
  .frm_vld_o   (frm_vld_o),
  .frm_acc_o   (frm_acc_o),
  .frm_rsn_o   (frm_rsn_o)
);

// File: tb/eth_da_filter_tb_top.sv
`timescale 1ns/1ps
module eth_da_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        da_valid;
  logic [47:0] da;
  logic        eof_valid;
  logic [15:0] eof_len;
  logic        eof_crc_ok;
  logic        addr_vld, addr_acc, frm_vld, frm_acc;
  logic [2:0]  addr_rsn, frm_rsn;

  always #2.5 clk = ~clk;

  eth_da_filter dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_addr_i   (cfg_addr),
    .cfg_wdata_i  (cfg_wdata),
    .da_valid_i   (da_valid),
    .da_i         (da),
    .eof_valid_i  (eof_valid),
    .eof_len_i    (eof_len),
    .eof_crc_ok_i (eof_crc_ok),
    .addr_vld_o   (addr_vld),
    .addr_acc_o   (addr_acc),
    .addr_rsn_o   (addr_rsn),
    .frm_vld_o    (frm_vld),
    .frm_acc_o    (frm_acc),
    .frm_rsn_o    (frm_rsn)
  );

  // ---------------- reference model ----------------
  logic [47:0] m_ent [15];
  logic [14:0] m_ena;
  logic [3:0]  m_mode;
  int          m_max;
  logic        e_av, e_aa, e_fv, e_fa;
  logic [2:0]  e_ar, e_fr;

  function automatic logic [2:0] ref_rsn(input logic [47:0] a);
    bit hit = 0;
    for (int i = 0; i < 15; i++)
      if (m_mode[0] && m_ena[i] && m_ent[i] == a) hit = 1;
    if (m_mode[1] && a == 48'hFFFF_FFFF_FFFF) return 3'd1;
    if (hit) return 3'd2;
    if (m_mode[2] && a[40]) return 3'd3;
    if (m_mode[3] && !a[40]) return 3'd4;
    return 3'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 15; i++) m_ent[i] = '0;
      m_ena = '0; m_mode = '0; m_max = 1518;
      e_av = 0; e_aa = 0; e_ar = 0; e_fv = 0; e_fa = 0; e_fr = 0;
    end else begin
      e_fv = eof_valid;
      if (eof_valid) begin
        if (!e_aa) e_fr = 3'd0;
        else if (int'(eof_len) > m_max) e_fr = 3'd5;
        else if (!eof_crc_ok) e_fr = 3'd6;
        else e_fr = e_ar;
        e_fa = (e_fr >= 3'd1 && e_fr <= 3'd4);
      end
      e_av = da_valid;
      if (da_valid) begin
        e_ar = ref_rsn(da);
        e_aa = (e_ar != 3'd0);
      end
      if (cfg_we) begin
        if (cfg_addr < 6'd30) begin
          if (cfg_addr[0]) m_ent[cfg_addr >> 1][15:0]  = cfg_wdata[31:16];
          else             m_ent[cfg_addr >> 1][47:16] = cfg_wdata;
        end
        else if (cfg_addr == 6'd30) m_ena  = cfg_wdata[14:0];
        else if (cfg_addr == 6'd31) m_mode = cfg_wdata[3:0];
        else if (cfg_addr == 6'd32) m_max  = int'(cfg_wdata[15:0]);
      end
    end
  end

  // ---------------- comparison every clock ----------------
  int    nvec = 0;
  int    nerr = 0;
  string cur_req = "R1";
  bit    run = 0;

  always @(negedge clk) begin
    if (run) begin
      nvec++;
      if ({addr_vld, addr_acc, addr_rsn, frm_vld, frm_acc, frm_rsn} !==
          {e_av, e_aa, e_ar, e_fv, e_fa, e_fr}) begin
        nerr++;
        $display("FAIL %s t=%0t actual av=%b aa=%b ar=%0d fv=%b fa=%b fr=%0d expected av=%b aa=%b ar=%0d fv=%b fa=%b fr=%0d",
                 cur_req, $time, addr_vld, addr_acc, addr_rsn, frm_vld, frm_acc, frm_rsn,
                 e_av, e_aa, e_ar, e_fv, e_fa, e_fr);
      end
    end
  end

  // ---------------- stimulus ----------------
  localparam logic [47:0] OWN   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OWN_X = 48'h02_11_22_33_44_54;
  localparam logic [47:0] GRP1  = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] GRP2  = 48'h33_33_00_00_00_07;
  localparam logic [47:0] IND2  = 48'h00_AA_BB_CC_DD_EE;
  localparam logic [47:0] BCST  = 48'hFFFF_FFFF_FFFF;

  task automatic cyc();
    @(posedge clk); #1;
    cfg_we = 0; da_valid = 0; eof_valid = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; cyc();
  endtask

  task automatic set_entry(input int i, input logic [47:0] mac);
    wr(6'(2 * i), mac[47:16]);
    wr(6'(2 * i + 1), {mac[15:0], 16'h0});
  endtask

  task automatic frame(input logic [47:0] mac, input int len, input bit crc);
    da_valid = 1; da = mac; cyc();
    cyc();
    eof_valid = 1; eof_len = 16'(len); eof_crc_ok = crc; cyc();
    cyc();
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    da_valid = 0; da = '0; eof_valid = 0; eof_len = '0; eof_crc_ok = 1;
    run = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: unconfigured block drops everything
    cur_req = "R1";
    frame(OWN, 100, 1); frame(BCST, 64, 1); frame(GRP1, 64, 1);

    // R3: table entries, exact 48-bit match
    cur_req = "R3";
    set_entry(0, OWN); wr(6'd30, 32'h1); wr(6'd31, 32'h1);
    frame(OWN, 100, 1); frame(OWN_X, 100, 1);
    set_entry(1, GRP1); wr(6'd30, 32'h3);
    frame(GRP1, 80, 1);

    // R4: mask of 1 keeps only the own-address entry
    cur_req = "R4";
    wr(6'd30, 32'h1);
    frame(GRP1, 80, 1); frame(OWN, 80, 1);

    // R5: compare enable off disables the table
    cur_req = "R5";
    wr(6'd30, 32'h3); wr(6'd31, 32'h0);
    frame(OWN, 80, 1); frame(GRP1, 80, 1);

    // R6: broadcast bypass
    cur_req = "R6";
    wr(6'd31, 32'h2);
    frame(BCST, 64, 1); frame(GRP2, 64, 1);

    // R7: all-group bypass
    cur_req = "R7";
    wr(6'd31, 32'h4);
    frame(GRP2, 64, 1); frame(BCST, 64, 1); frame(IND2, 64, 1);

    // R8: all-individual bypass, then promiscuous
    cur_req = "R8";
    wr(6'd31, 32'h8);
    frame(IND2, 64, 1); frame(GRP2, 64, 1);
    wr(6'd31, 32'hC);
    frame(IND2, 64, 1); frame(GRP2, 64, 1); frame(BCST, 64, 1);

    // R9: priority with every path open
    cur_req = "R9";
    set_entry(2, BCST); wr(6'd30, 32'h7); wr(6'd31, 32'hF);
    frame(BCST, 64, 1); frame(OWN, 64, 1); frame(GRP1, 64, 1);
    frame(GRP2, 64, 1); frame(IND2, 64, 1);
    wr(6'd31, 32'h1);
    frame(BCST, 64, 1);

    // R10: length limit, CRC counted
    cur_req = "R10";
    frame(OWN, 1518, 1); frame(OWN, 1519, 1);
    wr(6'd32, 32'd64);
    frame(OWN, 64, 1); frame(OWN, 65, 1);

    // R11: CRC status and drop ordering
    cur_req = "R11";
    frame(OWN, 64, 0); frame(OWN, 65, 0); frame(IND2, 2000, 0);
    wr(6'd32, 32'd1518);

    // R2: back-to-back and sparse strobes
    cur_req = "R2";
    da_valid = 1; da = OWN; cyc();
    da_valid = 1; da = IND2; cyc();
    da_valid = 1; da = OWN; cyc();
    cyc(); cyc();
    eof_valid = 1; eof_len = 16'd300; eof_crc_ok = 1; cyc();
    eof_valid = 1; eof_len = 16'd1600; cyc();
    cyc();

    // mixed random traffic against the model (R9 R10 R11)
    cur_req = "R9";
    for (int k = 0; k < 400; k++) begin
      int sel;
      logic [47:0] pool [6];
      pool[0] = OWN; pool[1] = OWN_X; pool[2] = GRP1;
      pool[3] = GRP2; pool[4] = IND2; pool[5] = BCST;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) wr(6'd31, 32'($urandom_range(0, 15)));
      else if (sel == 1) wr(6'd30, 32'($urandom_range(0, 32767)));
      else begin
        da_valid = 1; da = pool[$urandom_range(0, 5)]; cyc();
        if ($urandom_range(0, 1) == 1) cyc();
        eof_valid = 1;
        eof_len = 16'(1514 + $urandom_range(0, 8));
        eof_crc_ok = ($urandom_range(0, 3) != 0);
        cyc();
      end
    end
    cyc(); cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule